// File: doc/BRIEF.md
# Scattered-Pilot Symbol Buffer with Time Interpolator

This block keeps the scattered pilots of the last several OFDM symbols. It also forms time-interpolated pilot estimates that a channel estimator consumes. Storage is split into `NSLOT` symbol slots, seven by default. Each slot has its own real memory and its own imaginary memory, and each slot holds exactly one symbol. A slot pointer picks the slot that the incoming symbol overwrites. The pointer steps round-robin at every symbol start.

Every pilot write also reads the entry it replaces, in the same cycle. That old value goes into a small set of holding registers. The estimator can therefore still ask for the pilot of the displaced symbol, seven symbols back, after its address has already been rewritten.

A read request names an address, a symbol age and a quarter-step weight. The block fetches the near pilot `a` at that age and the far pilot `b` four symbols older. It returns `(4-p)*a + p*b` for the real part and for the imaginary part. The multiplies are done as shifts feeding a carry-save stage and one carry-propagate adder. The result keeps two fractional bits and no truncation.

Top module: `pilot_buf`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `out_valid` is 0. The slot pointer restarts at slot 0.
- R2: A write with `wr_valid` stores `wr_re`/`wr_im` at `wr_addr` in the slot under the pointer. A later read of age 0 with weight 0 returns exactly 4 times the stored value.
- R3: Each `sym_start` pulse moves the pointer to the next slot, and slot `NSLOT-1` wraps to slot 0. Age k (0 to `NSLOT-1`) addresses slot (pointer − k) mod `NSLOT`.
- R4: A read issued in the same cycle as a write to the same slot and address returns the contents from before that write.
- R5: Each accepted request produces exactly one `out_valid` pulse, two clock cycles later. Back-to-back requests give back-to-back results in request order.
- R6: Age `NSLOT` is the symbol displaced from the current slot. Its pilot comes from memory if the address has not been rewritten since the last `sym_start`. It comes from the holding registers if the address was rewritten within the last `HOLD` writes.
- R7: If one address is rewritten more than once within the holding window, an age-`NSLOT` read returns the displaced symbol's pilot. It does not return the value from the current symbol.
- R8: `sym_start` clears the holding registers. A later age-`NSLOT` read takes the newly displaced symbol's pilot from memory, never a stale held one.
- R9: `rd_phase` p (0..3) selects the output `(4-p)*a + p*b`, where `a` is the pilot at age `rd_age` and `b` is the pilot at age `rd_age+4`. The real and imaginary parts are computed independently. `rd_age` must not exceed `NSLOT-4`.
- R10: The output is `DW+2` bits signed and exact for all inputs, including the most negative and most positive pilot values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_start | input | 1 | Symbol start; advances the slot pointer and clears held values |
| wr_valid | input | 1 | Pilot write strobe |
| wr_addr | input | $clog2(DEPTH) | Pilot index within the symbol |
| wr_re | input | DW | Pilot real part, signed |
| wr_im | input | DW | Pilot imaginary part, signed |
| rd_valid | input | 1 | Interpolation request strobe |
| rd_addr | input | $clog2(DEPTH) | Pilot index to read |
| rd_age | input | $clog2(NSLOT+1) | Age of the near symbol relative to the pointer |
| rd_phase | input | 2 | Quarter-step weight toward the far symbol |
| out_valid | output | 1 | Result strobe, two cycles after the request |
| out_re | output | DW+2 | Interpolated real part, two fractional bits |
| out_im | output | DW+2 | Interpolated imaginary part, two fractional bits |

## Verification
The bench builds the block with `NSLOT=7`, `DEPTH=16`, `DW=8` and `HOLD=2`. The shallow depth makes it cheap to fill all seven slots and wrap the pointer, so the displaced-symbol path can be reached both from memory and from the holding registers. Eight-bit pilots put the extreme values −128 and 127 in reach, which tests the exactness of the weighted sums. A holding depth of two lets one address written twice occupy both entries, which exercises the oldest-entry priority.

// File: rtl/pilot_buf_pkg.sv
package pilot_buf_pkg;
   // symbols between the near and far pilot used for interpolation
   localparam int SPAN = 4;

   // quarter-step weight toward the far pilot
   typedef enum logic [1:0] {
      W_NEAR = 2'd0,
      W_QTR  = 2'd1,
      W_HALF = 2'd2,
      W_3QTR = 2'd3
   } wgt_e;
endpackage

// File: rtl/pb_slot_ptr.sv
module pb_slot_ptr #(
   parameter int NSLOT = 7,
   parameter int PW    = $clog2(NSLOT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [PW-1:0] ptr
);
   localparam logic [PW-1:0] LAST = PW'(NSLOT - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr <= '0;
      else if (adv)
         ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end
endmodule

// File: rtl/pb_pilot_store.sv
module pb_pilot_store #(
   parameter int NSLOT = 7,
   parameter int DEPTH = 128,
   parameter int DW    = 12,
   parameter int AW    = $clog2(DEPTH),
   parameter int PW    = $clog2(NSLOT)
) (
   input  logic                 clk,
   input  logic                 wr_en,
   input  logic [PW-1:0]        wr_slot,
   input  logic [AW-1:0]        wr_addr,
   input  logic signed [DW-1:0] wr_re,
   input  logic signed [DW-1:0] wr_im,
   input  logic [AW-1:0]        rd_addr,
   input  logic [PW-1:0]        rd_slot_a,
   input  logic [PW-1:0]        rd_slot_b,
   output logic signed [DW-1:0] rd_a_re,
   output logic signed [DW-1:0] rd_a_im,
   output logic signed [DW-1:0] rd_b_re,
   output logic signed [DW-1:0] rd_b_im,
   output logic signed [DW-1:0] pre_re,
   output logic signed [DW-1:0] pre_im
);
   logic signed [DW-1:0] slot_rd_re  [NSLOT];
   logic signed [DW-1:0] slot_rd_im  [NSLOT];
   logic signed [DW-1:0] slot_pre_re [NSLOT];
   logic signed [DW-1:0] slot_pre_im [NSLOT];

   // one real and one imaginary array per symbol slot
   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic signed [DW-1:0] m_re [DEPTH];
      logic signed [DW-1:0] m_im [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && (wr_slot == PW'(s))) begin
            m_re[wr_addr] <= wr_re;
            m_im[wr_addr] <= wr_im;
         end
      end

      assign slot_rd_re[s]  = m_re[rd_addr];
      assign slot_rd_im[s]  = m_im[rd_addr];
      assign slot_pre_re[s] = m_re[wr_addr];
      assign slot_pre_im[s] = m_im[wr_addr];
   end

   assign rd_a_re = slot_rd_re[rd_slot_a];
   assign rd_a_im = slot_rd_im[rd_slot_a];
   assign rd_b_re = slot_rd_re[rd_slot_b];
   assign rd_b_im = slot_rd_im[rd_slot_b];
   assign pre_re  = slot_pre_re[wr_slot];
   assign pre_im  = slot_pre_im[wr_slot];
endmodule

// File: rtl/pb_hold.sv
module pb_hold #(
   parameter int HOLD = 2,
   parameter int AW   = 7,
   parameter int DW   = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 push,
   input  logic [AW-1:0]        push_addr,
   input  logic signed [DW-1:0] push_re,
   input  logic signed [DW-1:0] push_im,
   input  logic [AW-1:0]        look_addr,
   output logic                 hit,
   output logic signed [DW-1:0] hit_re,
   output logic signed [DW-1:0] hit_im
);
   logic                 h_v  [HOLD];
   logic [AW-1:0]        h_a  [HOLD];
   logic signed [DW-1:0] h_re [HOLD];
   logic signed [DW-1:0] h_im [HOLD];

   // entry 0 is the newest pre-read value
   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         for (int i = 0; i < HOLD; i++) h_v[i] <= 1'b0;
      end else if (push) begin
         for (int i = HOLD - 1; i > 0; i--) begin
            h_v[i]  <= h_v[i-1];
            h_a[i]  <= h_a[i-1];
            h_re[i] <= h_re[i-1];
            h_im[i] <= h_im[i-1];
         end
         h_v[0]  <= 1'b1;
         h_a[0]  <= push_addr;
         h_re[0] <= push_re;
         h_im[0] <= push_im;
      end
   end

   // the oldest matching entry wins: it holds the displaced symbol's value
   always_comb begin
      hit    = 1'b0;
      hit_re = '0;
      hit_im = '0;
      for (int i = 0; i < HOLD; i++) begin
         if (h_v[i] && (h_a[i] == look_addr)) begin
            hit    = 1'b1;
            hit_re = h_re[i];
            hit_im = h_im[i];
         end
      end
   end
endmodule

// File: rtl/pb_interp.sv
module pb_interp
   import pilot_buf_pkg::*;
#(
   parameter int DW      = 12,
   parameter bit USE_CSA = 1'b1,
   parameter int OW      = DW + 2
) (
   input  logic signed [DW-1:0] a,
   input  logic signed [DW-1:0] b,
   input  wgt_e                 w,
   output logic signed [OW-1:0] y
);
   logic signed [OW-1:0] ax, bx, x0, x1, x2;

   assign ax = {{(OW-DW){a[DW-1]}}, a};
   assign bx = {{(OW-DW){b[DW-1]}}, b};

   // (4-p)*a + p*b as three shifted terms
   always_comb begin
      unique case (w)
         W_NEAR: begin x0 = ax <<< 2; x1 = '0;       x2 = '0; end
         W_QTR:  begin x0 = ax <<< 1; x1 = ax;       x2 = bx; end
         W_HALF: begin x0 = ax <<< 1; x1 = bx <<< 1; x2 = '0; end
         default: begin x0 = ax;      x1 = bx <<< 1; x2 = bx; end
      endcase
   end

   if (USE_CSA) begin : g_csa
      logic [OW-1:0] sv, mj;
      assign sv = x0 ^ x1 ^ x2;
      assign mj = (x0 & x1) | (x0 & x2) | (x1 & x2);
      assign y  = $signed(sv) + $signed({mj[OW-2:0], 1'b0});
   end else begin : g_ripple
      assign y = x0 + x1 + x2;
   end
endmodule

// File: rtl/pilot_buf.sv
module pilot_buf
   import pilot_buf_pkg::*;
#(
   parameter int NSLOT   = 7,
   parameter int DEPTH   = 128,
   parameter int DW      = 12,
   parameter int HOLD    = 2,
   parameter bit USE_CSA = 1'b1,
   parameter int AW      = $clog2(DEPTH),
   parameter int AGEW    = $clog2(NSLOT + 1),
   parameter int OW      = DW + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sym_start,
   input  logic                 wr_valid,
   input  logic [AW-1:0]        wr_addr,
   input  logic signed [DW-1:0] wr_re,
   input  logic signed [DW-1:0] wr_im,
   input  logic                 rd_valid,
   input  logic [AW-1:0]        rd_addr,
   input  logic [AGEW-1:0]      rd_age,
   input  logic [1:0]           rd_phase,
   output logic                 out_valid,
   output logic signed [OW-1:0] out_re,
   output logic signed [OW-1:0] out_im
);
   localparam int PW = $clog2(NSLOT);

   if (NSLOT <= SPAN) begin : g_bad_nslot
      $error("pilot_buf: NSLOT must exceed the interpolation span");
   end
   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("pilot_buf: DEPTH must be a power of two");
   end
   if (HOLD < 1) begin : g_bad_hold
      $error("pilot_buf: HOLD must be at least 1");
   end

   function automatic logic [PW-1:0] slot_of(input logic [PW-1:0] p, input int age);
      int t;
      t = int'(p) - age;
      if (t < 0) t = t + NSLOT;
      return PW'(t);
   endfunction

   logic [PW-1:0]        ptr;
   logic [PW-1:0]        slot_a, slot_b;
   logic                 far_disp;
   int                   far_age;
   logic signed [DW-1:0] mem_a_re, mem_a_im, mem_b_re, mem_b_im;
   logic signed [DW-1:0] pre_re, pre_im;
   logic                 hold_hit;
   logic signed [DW-1:0] hold_re, hold_im;

   pb_slot_ptr #(.NSLOT(NSLOT), .PW(PW)) u_ptr (
      .clk(clk), .rst_n(rst_n), .adv(sym_start), .ptr(ptr)
   );

   assign far_age  = int'(rd_age) + SPAN;
   assign far_disp = (far_age == NSLOT);
   assign slot_a   = slot_of(ptr, int'(rd_age));
   assign slot_b   = far_disp ? ptr : slot_of(ptr, far_age);

   pb_pilot_store #(.NSLOT(NSLOT), .DEPTH(DEPTH), .DW(DW), .AW(AW), .PW(PW)) u_store (
      .clk(clk), .wr_en(wr_valid), .wr_slot(ptr), .wr_addr(wr_addr),
      .wr_re(wr_re), .wr_im(wr_im), .rd_addr(rd_addr),
      .rd_slot_a(slot_a), .rd_slot_b(slot_b),
      .rd_a_re(mem_a_re), .rd_a_im(mem_a_im),
      .rd_b_re(mem_b_re), .rd_b_im(mem_b_im),
      .pre_re(pre_re), .pre_im(pre_im)
   );

   pb_hold #(.HOLD(HOLD), .AW(AW), .DW(DW)) u_hold (
      .clk(clk), .rst_n(rst_n), .clr(sym_start), .push(wr_valid),
      .push_addr(wr_addr), .push_re(pre_re), .push_im(pre_im),
      .look_addr(rd_addr), .hit(hold_hit), .hit_re(hold_re), .hit_im(hold_im)
   );

   // stage 1: fetched pilots
   logic                 s1_v;
   wgt_e                 s1_w;
   logic signed [DW-1:0] s1_a_re, s1_a_im, s1_b_re, s1_b_im;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_w    <= W_NEAR;
         s1_a_re <= '0;
         s1_a_im <= '0;
         s1_b_re <= '0;
         s1_b_im <= '0;
      end else begin
         s1_v    <= rd_valid;
         s1_w    <= wgt_e'(rd_phase);
         s1_a_re <= mem_a_re;
         s1_a_im <= mem_a_im;
         s1_b_re <= (far_disp && hold_hit) ? hold_re : mem_b_re;
         s1_b_im <= (far_disp && hold_hit) ? hold_im : mem_b_im;
      end
   end

   // stage 2: weighted sums
   logic signed [OW-1:0] y_re, y_im;

   pb_interp #(.DW(DW), .USE_CSA(USE_CSA), .OW(OW)) u_int_re (
      .a(s1_a_re), .b(s1_b_re), .w(s1_w), .y(y_re)
   );
   pb_interp #(.DW(DW), .USE_CSA(USE_CSA), .OW(OW)) u_int_im (
      .a(s1_a_im), .b(s1_b_im), .w(s1_w), .y(y_im)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_re    <= '0;
         out_im    <= '0;
      end else begin
         out_valid <= s1_v;
         out_re    <= y_re;
         out_im    <= y_im;
      end
   end
endmodule

// File: rtl/pilot_buf_chk.sv
module pilot_buf_chk
   import pilot_buf_pkg::*;
#(
   parameter int NSLOT = 7,
   parameter int AGEW  = 3,
   parameter int PW    = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            sym_start,
   input logic            rd_valid,
   input logic [AGEW-1:0] rd_age,
   input logic            out_valid,
   input logic [PW-1:0]   ptr,
   input logic            hold_hit
);
   assert_result_lat_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ##2 out_valid);

   assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> ##2 !out_valid);

   assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr) < NSLOT);

   assert_ptr_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_start |=> $stable(ptr));

   assert_ptr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_start && int'(ptr) == NSLOT - 1) |=> ptr == '0);

   assert_hold_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sym_start |=> !hold_hit);

   assert_age_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> int'(rd_age) <= NSLOT - SPAN);
endmodule

bind pilot_buf pilot_buf_chk #(.NSLOT(NSLOT), .AGEW(AGEW), .PW(PW)) u_chk (
   .clk(clk), .rst_n(rst_n), .sym_start(sym_start), .rd_valid(rd_valid),
   .rd_age(rd_age), .out_valid(out_valid), .ptr(ptr), .hold_hit(hold_hit)
);

// File: tb/pilot_buf_tb.sv
module pilot_buf_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NSLOT = 7;
   localparam int DEPTH = 16;
   localparam int DW    = 8;
   localparam int HOLD  = 2;
   localparam int AW    = 4;
   localparam int AGEW  = 3;
   localparam int OW    = DW + 2;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 sym_start = 1'b0;
   logic                 wr_valid = 1'b0;
   logic [AW-1:0]        wr_addr = '0;
   logic signed [DW-1:0] wr_re = '0;
   logic signed [DW-1:0] wr_im = '0;
   logic                 rd_valid = 1'b0;
   logic [AW-1:0]        rd_addr = '0;
   logic [AGEW-1:0]      rd_age = '0;
   logic [1:0]           rd_phase = '0;
   logic                 out_valid;
   logic signed [OW-1:0] out_re, out_im;

   always #(CLK_PERIOD/2) clk = ~clk;

   pilot_buf #(.NSLOT(NSLOT), .DEPTH(DEPTH), .DW(DW), .HOLD(HOLD)) u_dut (
      .clk(clk), .rst_n(rst_n), .sym_start(sym_start), .wr_valid(wr_valid),
      .wr_addr(wr_addr), .wr_re(wr_re), .wr_im(wr_im), .rd_valid(rd_valid),
      .rd_addr(rd_addr), .rd_age(rd_age), .rd_phase(rd_phase),
      .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // reference state built from the requirements
   int model_re [NSLOT][DEPTH];
   int model_im [NSLOT][DEPTH];
   int disp_re  [DEPTH];
   int disp_im  [DEPTH];
   int mptr = 0;

   int    q_re [$];
   int    q_im [$];
   string q_tag [$];

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int mval(input int age, input int a, input bit im);
      int s;
      if (age == NSLOT) return im ? disp_im[a] : disp_re[a];
      s = (mptr + NSLOT - age) % NSLOT;
      return im ? model_im[s][a] : model_re[s][a];
   endfunction

   function automatic int vre(input int s, input int a);
      if (a == 0) return (s % 2 == 1) ? -128 : 127;
      return ((s * 29 + a * 13 + 5) % 200) - 100;
   endfunction

   function automatic int vim(input int s, input int a);
      if (a == 0) return (s % 2 == 1) ? 127 : -128;
      return ((s * 17 + a * 7 + 1) % 200) - 100;
   endfunction

   // driver: one cycle of stimulus; pushes the expected result of a request
   task automatic step(input bit sym, input bit wv, input int wa, input int wre, input int wim,
                       input bit rv, input int ra, input int near, input int ph,
                       input string tag);
      @(negedge clk);
      sym_start = sym;
      wr_valid  = wv;
      wr_addr   = AW'(wa);
      wr_re     = DW'(wre);
      wr_im     = DW'(wim);
      rd_valid  = rv;
      rd_addr   = AW'(ra);
      rd_age    = AGEW'(near);
      rd_phase  = 2'(ph);
      if (rv) begin
         q_re.push_back((4 - ph) * mval(near, ra, 1'b0) + ph * mval(near + 4, ra, 1'b0));
         q_im.push_back((4 - ph) * mval(near, ra, 1'b1) + ph * mval(near + 4, ra, 1'b1));
         q_tag.push_back(tag);
      end
      @(posedge clk);
      if (wv) begin
         model_re[mptr][wa] = wre;
         model_im[mptr][wa] = wim;
      end
      if (sym) begin
         mptr = (mptr + 1) % NSLOT;
         for (int a = 0; a < DEPTH; a++) begin
            disp_re[a] = model_re[mptr][a];
            disp_im[a] = model_im[mptr][a];
         end
      end
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
   endtask

   task automatic wr(input int a, input int re, input int im);
      step(0, 1, a, re, im, 0, 0, 0, 0, "");
   endtask

   task automatic rq(input int a, input int near, input int ph, input string tag);
      step(0, 0, 0, 0, 0, 1, a, near, ph, tag);
   endtask

   // monitor: compares each result against the oldest expected item
   always @(negedge clk) begin : mon
      int    er, ei;
      string tg;
      if (rst_n && out_valid) begin
         if (q_re.size() == 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R5 unexpected result actual=%0d expected=none", int'(out_re));
         end else begin
            er = q_re.pop_front();
            ei = q_im.pop_front();
            tg = q_tag.pop_front();
            check({tg, " re"}, int'(out_re), er);
            check({tg, " im"}, int'(out_im), ei);
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      int addrs [3] = '{0, 3, 15};
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 out_valid in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 out_valid after reset", int'(out_valid), 0);

      // R2 R3: fill seven symbols, one per slot, pointer wraps back to slot 0
      for (int s = 0; s < NSLOT; s++) begin
         for (int a = 0; a < DEPTH; a++) wr(a, vre(s, a), vim(s, a));
         step(1, 0, 0, 0, 0, 0, 0, 0, 0, "");
      end

      // R9 R10 R5 R6: all ages and weights, back to back, extremes at address 0
      for (int n = 0; n < 4; n++)
         for (int p = 0; p < 4; p++)
            for (int k = 0; k < 3; k++)
               rq(addrs[k], n, p, $sformatf("R9 R10 R3 age%0d ph%0d addr%0d", n, p, addrs[k]));
      idle();
      idle();

      // R4: request in the same cycle as a write to the same place
      step(0, 1, 5, 77, -77, 1, 5, 0, 1, "R4 read-before-write age0");
      // R6: displaced pilot served from the holding registers
      rq(5, 3, 3, "R6 held displaced addr5");
      // R7: address rewritten twice; oldest held value wins
      wr(6, 11, 12);
      wr(6, 21, 22);
      rq(6, 3, 2, "R7 oldest held entry addr6");
      rq(6, 0, 0, "R2 latest write addr6");
      // R6: displaced pilot not yet rewritten comes from memory
      rq(9, 3, 1, "R6 displaced from memory addr9");
      step(0, 1, 9, -50, 50, 1, 9, 3, 3, "R4 same-cycle displaced addr9");
      wr(12, 33, -33);
      // R8: symbol start clears held values
      step(1, 0, 0, 0, 0, 0, 0, 0, 0, "");
      rq(12, 3, 3, "R8 no stale hold addr12");
      rq(12, 0, 0, "R3 advanced slot addr12");
      rq(5, 3, 3, "R8 no stale hold addr5");
      repeat (5) idle();

      check("R5 all results returned", q_re.size(), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule